// File: doc/BRIEF.md
# Smart-Card Character Transceiver (T=0)

This block moves single characters over a half-duplex smart-card link that uses one shared, open-drain I/O line. It is the master of the link. It produces the card clock by dividing the system clock, and it times every bit as a fixed number of card-clock cycles. A mode input selects one direction at a time. In transmit mode the block takes a byte from the host through a valid/ready handshake. It sends a low start bit, eight data bits and an even-parity bit, then lets go of the line for a two-bit guard period. During that period it watches for the card signalling a parity error.

In receive mode the block waits for a falling edge on the line. It confirms the start bit at the middle of that bit, then samples each following bit at the middle of its period. The byte and a parity-error flag go to the host on a one-cycle strobe. When the parity check fails, the block pulls the line low for one bit period, starting half a bit into the guard time, so the card knows to repeat the character. Data is never complemented internally. Any inverse-convention handling belongs to the host.

Top module: `sc_t0_xcvr`

## Requirements
- R1: `card_clk` runs freely. Each half period lasts `clk_div` system clocks, and a value of 0 counts as 1. A card tick is a rising edge of `card_clk`, and one bit period (ETU) is `ETU_TICKS` ticks.
- R2: A transmitted character is one low start bit, eight data bits and one parity bit, each one ETU long. The parity bit is the XOR of the eight data bits, so the count of ones is even. Transmission starts on the tick at which `tx_valid` and `tx_ready` are both high.
- R3: When `msb_first`=1, data bit 7 goes first on the line and is also the first bit received. When `msb_first`=0, bit 0 goes first.
- R4: The transmitter never drives the line during the two-ETU guard period. `tx_done` pulses on the tick that ends the guard. If the card did not signal an error and `tx_valid` is high on that tick, the next start bit begins at once, so start bits are exactly 12 ETU apart.
- R5: The line output is open-drain. `io_drive_low`=1 pulls the line low. A 1 data bit, an idle block and a block in reset all leave the line released.
- R6: `tx_ready` is low whenever `mode_rx`=1. In receive mode the block drives the line only for the parity-error signal.
- R7: In receive mode, a falling edge on the line starts a character. The start bit is checked half an ETU into the character. If the line is high at that point, the character is dropped and the block waits for a new falling edge.
- R8: `rx_valid` pulses for one cycle at the end of the receive guard period. It comes with the byte in `rx_data` and `rx_perr`=1 when data plus parity hold an odd count of ones.
- R9: On a receive parity error, `io_drive_low` is high for exactly one ETU, starting half an ETU into the guard period. Without an error it stays low throughout the guard period.
- R10: If the line reads low one ETU into the transmit guard period, `tx_done` comes with `tx_err`=1. The byte is then held, and `tx_ready` stays low until `tx_resend` sends the same byte again.
- R11: During and right after reset, `io_drive_low`, `card_clk`, `tx_done` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | System clocks per half period of the card clock |
| mode_rx | input | 1 | 1 selects receive, 0 selects transmit |
| msb_first | input | 1 | Data bit order on the line |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_ready | output | 1 | Block accepts the byte on this cycle |
| tx_resend | input | 1 | Retransmit the byte held after an error |
| tx_done | output | 1 | One-cycle strobe when a transmitted character ends |
| tx_err | output | 1 | Card signalled an error on the last character |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe with a received byte |
| rx_perr | output | 1 | Parity error on the received byte |
| io_in | input | 1 | Level of the shared I/O line |
| io_drive_low | output | 1 | Pull the shared line low |
| card_clk | output | 1 | Clock supplied to the card |

## Verification
Some properties are checked on every cycle. The line stays released throughout the transmit guard and while the block hunts for or receives bits. `tx_ready` is never high in receive mode or while a byte is held after an error. The receive-side drive happens only when a parity error has been recorded. Both strobes last a single cycle. Other behaviour can only be shown by the bench's scenarios, run against a card model that counts card-clock edges: the exact bit timing and bit order of transmitted characters, the 12-ETU back-to-back spacing, the placement and length of the error pulse, false-start rejection, and the hold-and-resend sequence after a signalled error.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_BITS,
        ST_TX_GUARD,
        ST_RX_HUNT,
        ST_RX_BITS,
        ST_RX_GUARD
    } sc_state_e;

    // index 0 = start bit, 1..8 = data, 9 = parity; guard uses 0..1
    localparam logic [3:0] LAST_BIT_IDX = 4'd9;

    typedef struct packed {
        sc_state_e   st;
        logic [3:0]  idx;
        logic [7:0]  dat;
        logic        perr;     // running parity of received bits
        logic        nack;     // card pulled the line during transmit guard
        logic        held;     // byte kept for resend
        logic        prev;     // line level at previous tick while hunting
        logic        rx_stb;
        logic        tx_stb;
        logic        tx_bad;
        logic [7:0]  rx_byte;
        logic        rx_bad;
    } sc_regs_t;

endpackage

// File: rtl/sc_clk_gen.sv
module sc_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             sclk_d, sclk_q;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim    = (div_i == '0) ? '0 : div_i - 1'b1;
        wrap   = (cnt_q >= lim);
        cnt_d  = wrap ? '0 : cnt_q + 1'b1;
        sclk_d = wrap ? ~sclk_q : sclk_q;
        tick_o = wrap && !sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sclk_q <= sclk_d;
        end
    end

    assign sclk_o = sclk_q;
endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
    parameter int ETU_TICKS = 372,
    parameter int CNT_W     = $clog2(ETU_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(ETU_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)   cnt_d = '0;
        else if (tick_i) cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = line_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], line_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];
endmodule

// File: rtl/sc_t0_xcvr.sv
module sc_t0_xcvr
    import sc_t0_pkg::*;
#(
    parameter int ETU_TICKS   = 372,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             mode_rx,
    input  logic             msb_first,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             tx_resend,
    output logic             tx_done,
    output logic             tx_err,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_perr,
    input  logic             io_in,
    output logic             io_drive_low,
    output logic             card_clk
);
    localparam int CNT_W = $clog2(ETU_TICKS);
    localparam int HALF  = ETU_TICKS / 2;
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ETU_TICKS - 1);

    sc_regs_t         r_d, r_q;
    logic             ck_tick;
    logic             line_s;
    logic             restart;
    logic [CNT_W-1:0] etu_cnt;
    logic             is_mid, is_last;
    logic [2:0]       data_pos;
    logic             ready_c, resend_c;
    logic             tx_bit;
    logic             err_win;

    sc_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (clk_div),
        .sclk_o (card_clk),
        .tick_o (ck_tick)
    );

    sc_etu_timer #(.ETU_TICKS(ETU_TICKS), .CNT_W(CNT_W)) u_etu (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (ck_tick),
        .restart_i (restart),
        .cnt_o     (etu_cnt)
    );

    sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (io_in),
        .line_o (line_s)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rx_stb = 1'b0;
        r_d.tx_stb = 1'b0;
        restart    = 1'b0;

        is_mid   = (etu_cnt == CNT_MID);
        is_last  = (etu_cnt == CNT_LAST);
        // idx 1..8 maps to data bit 0..7 (idx 8 wraps to 7 in three bits)
        data_pos = msb_first ? (3'd7 - (r_q.idx[2:0] - 3'd1)) : (r_q.idx[2:0] - 3'd1);

        ready_c  = ck_tick && !mode_rx &&
                   ((r_q.st == ST_IDLE && !r_q.held) ||
                    (r_q.st == ST_TX_GUARD && r_q.idx == 4'd1 && is_last && !r_q.nack));
        resend_c = ck_tick && !mode_rx && r_q.st == ST_IDLE && r_q.held && tx_resend;

        if ((tx_valid && ready_c) || resend_c) begin
            if (r_q.st == ST_TX_GUARD) begin
                r_d.tx_stb = 1'b1;
                r_d.tx_bad = 1'b0;
            end
            if (!resend_c) r_d.dat = tx_data;
            r_d.st   = ST_TX_BITS;
            r_d.idx  = '0;
            r_d.nack = 1'b0;
            r_d.held = 1'b0;
            restart  = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (ck_tick && mode_rx) begin
                        r_d.st   = ST_RX_HUNT;
                        r_d.prev = 1'b1;
                        r_d.held = 1'b0;
                    end
                end
                ST_TX_BITS: begin
                    if (ck_tick && is_last) begin
                        if (r_q.idx == LAST_BIT_IDX) begin
                            r_d.st  = ST_TX_GUARD;
                            r_d.idx = '0;
                        end else begin
                            r_d.idx = r_q.idx + 4'd1;
                        end
                    end
                end
                ST_TX_GUARD: begin
                    if (ck_tick) begin
                        if (r_q.idx == 4'd1 && etu_cnt == '0 && !line_s) r_d.nack = 1'b1;
                        if (is_last) begin
                            if (r_q.idx == 4'd1) begin
                                r_d.st     = ST_IDLE;
                                r_d.tx_stb = 1'b1;
                                r_d.tx_bad = r_q.nack;
                                r_d.held   = r_q.nack;
                            end else begin
                                r_d.idx = 4'd1;
                            end
                        end
                    end
                end
                ST_RX_HUNT: begin
                    if (ck_tick) begin
                        r_d.prev = line_s;
                        if (!mode_rx) begin
                            r_d.st = ST_IDLE;
                        end else if (r_q.prev && !line_s) begin
                            r_d.st   = ST_RX_BITS;
                            r_d.idx  = '0;
                            r_d.perr = 1'b0;
                            restart  = 1'b1;
                        end
                    end
                end
                ST_RX_BITS: begin
                    if (ck_tick) begin
                        if (is_mid) begin
                            if (r_q.idx == 4'd0) begin
                                if (line_s) begin
                                    r_d.st   = ST_RX_HUNT;
                                    r_d.prev = 1'b1;
                                end
                            end else begin
                                r_d.perr = r_q.perr ^ line_s;
                                if (r_q.idx <= 4'd8) r_d.dat[data_pos] = line_s;
                            end
                        end else if (is_last) begin
                            if (r_q.idx == LAST_BIT_IDX) begin
                                r_d.st  = ST_RX_GUARD;
                                r_d.idx = '0;
                            end else begin
                                r_d.idx = r_q.idx + 4'd1;
                            end
                        end
                    end
                end
                ST_RX_GUARD: begin
                    if (ck_tick && is_last) begin
                        if (r_q.idx == 4'd1) begin
                            r_d.st      = mode_rx ? ST_RX_HUNT : ST_IDLE;
                            r_d.prev    = 1'b1;
                            r_d.rx_stb  = 1'b1;
                            r_d.rx_byte = r_q.dat;
                            r_d.rx_bad  = r_q.perr;
                        end else begin
                            r_d.idx = 4'd1;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        if (r_q.idx == 4'd0)            tx_bit = 1'b0;
        else if (r_q.idx <= 4'd8)       tx_bit = r_q.dat[data_pos];
        else                            tx_bit = ^r_q.dat;

        err_win = r_q.st == ST_RX_GUARD && r_q.perr &&
                  ((r_q.idx == 4'd0 && etu_cnt >= CNT_MID) ||
                   (r_q.idx == 4'd1 && etu_cnt <  CNT_MID));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready     = ready_c;
    assign tx_done      = r_q.tx_stb;
    assign tx_err       = r_q.tx_bad;
    assign rx_valid     = r_q.rx_stb;
    assign rx_data      = r_q.rx_byte;
    assign rx_perr      = r_q.rx_bad;
    assign io_drive_low = (r_q.st == ST_TX_BITS && !tx_bit) || err_win;
endmodule

// File: rtl/sc_t0_chk.sv
module sc_t0_chk
    import sc_t0_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input sc_state_e st,
    input logic      perr,
    input logic      held,
    input logic      mode_rx,
    input logic      tx_ready,
    input logic      tx_done,
    input logic      rx_valid,
    input logic      io_drive_low
);
    assert_guard_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX_GUARD) |-> !io_drive_low);

    assert_ready_tx_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !mode_rx);

    assert_rx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX_HUNT || st == ST_RX_BITS) |-> !io_drive_low);

    assert_err_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX_GUARD && io_drive_low) |-> perr);

    assert_rx_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_tx_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !tx_ready);
endmodule

bind sc_t0_xcvr sc_t0_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (r_q.st),
    .perr         (r_q.perr),
    .held         (r_q.held),
    .mode_rx      (mode_rx),
    .tx_ready     (tx_ready),
    .tx_done      (tx_done),
    .rx_valid     (rx_valid),
    .io_drive_low (io_drive_low)
);

// File: tb/sim_sc_t0_xcvr.sv
module sim_sc_t0_xcvr;
    localparam int ETU  = 8;
    localparam int HALF = ETU / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_div = 8'd2;
    logic       mode_rx = 1'b0;
    logic       msb_first = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_resend = 1'b0;
    logic       tx_ready, tx_done, tx_err;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr;
    logic       io_drive_low, card_clk;
    logic       card_low = 1'b0;
    logic       io_line;

    int total = 0;
    int bad = 0;
    int clk_bad = 0;
    int cyc = 0;
    int t = 0;
    logic last_ck = 1'b0;
    bit got_done, cap_err, got_rx, cap_rxp, saw_drive, saw_ready;
    logic [7:0] cap_rxd;

    always #10 clk = ~clk;

    assign io_line = !(io_drive_low || card_low);

    sc_t0_xcvr #(.ETU_TICKS(ETU), .DIV_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .mode_rx(mode_rx),
        .msb_first(msb_first), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_resend(tx_resend), .tx_done(tx_done),
        .tx_err(tx_err), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .io_in(io_line), .io_drive_low(io_drive_low),
        .card_clk(card_clk)
    );

    // behavioural card-clock reference, compared on every clock (R1)
    int   m_cnt = 0;
    logic m_ck = 1'b0;
    always @(posedge clk) begin
        int lim;
        if (!rst_n) begin
            m_cnt = 0;
            m_ck  = 1'b0;
        end else begin
            lim = (clk_div == 0) ? 1 : int'(clk_div);
            if (m_cnt >= lim - 1) begin
                m_cnt = 0;
                m_ck  = !m_ck;
            end else begin
                m_cnt++;
            end
        end
    end
    always @(negedge clk) if (rst_n && card_clk !== m_ck) clk_bad++;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog expired: actual=%0d expected<=150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
        end
    endtask

    task automatic next_tick();
        forever begin
            @(negedge clk);
            if (card_clk && !last_ck) begin
                last_ck = card_clk;
                break;
            end
            last_ck = card_clk;
        end
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            next_tick();
            t++;
            if (rx_valid) begin got_rx = 1; cap_rxd = rx_data; cap_rxp = rx_perr; end
            if (tx_done)  begin got_done = 1; cap_err = tx_err; end
            if (io_drive_low) saw_drive = 1;
            if (tx_ready) saw_ready = 1;
        end
    endtask

    task automatic adv_to(input int target);
        if (target > t) adv(target - t);
    endtask

    // how: 0 = offer via tx_valid, 1 = tx_resend, 2 = already started
    task automatic tx_frame(input logic [7:0] d, input int how, input bit nack,
                            input bit chain, input logic [7:0] nd);
        logic [9:0] bits;
        logic [7:0] got;
        got_done = 0;
        if (how != 2) begin
            if (how == 0) begin tx_data = d; tx_valid = 1'b1; end
            else tx_resend = 1'b1;
            t = 0;
            adv(1);
        end
        t = 0;
        tx_valid  = 1'b0;
        tx_resend = 1'b0;
        chk(io_drive_low == 1'b1, "R5 start bit pulls line low", io_drive_low, 1);
        for (int k = 0; k < 10; k++) begin
            adv_to(k * ETU + HALF);
            bits[k] = io_line;
        end
        for (int j = 0; j < 8; j++) begin
            if (msb_first) got[7-j] = bits[j+1];
            else           got[j]   = bits[j+1];
        end
        chk(bits[0] == 1'b0, "R2 start bit level", bits[0], 0);
        chk(got == d, msb_first ? "R3 msb-first data" : "R2 lsb-first data", got, d);
        chk(bits[9] == ^d, "R2 even parity bit", bits[9], ^d);
        adv_to(10 * ETU + 1);
        chk(io_drive_low == 1'b0, "R4 released at guard start", io_drive_low, 0);
        if (nack) begin
            adv_to(10 * ETU + HALF);
            card_low = 1'b1;
            adv_to(11 * ETU + HALF);
            card_low = 1'b0;
        end else begin
            adv_to(11 * ETU + HALF);
            chk(io_drive_low == 1'b0, "R4 released in guard", io_drive_low, 0);
        end
        if (chain) begin
            adv_to(12 * ETU - 1);
            tx_data  = nd;
            tx_valid = 1'b1;
            adv(1);
            chk(io_drive_low == 1'b1, "R4 next start exactly 12 ETU later", io_drive_low, 1);
        end else begin
            adv_to(12 * ETU);
        end
        chk(got_done == 1'b1, "R4 tx_done at guard end", got_done, 1);
        chk(cap_err == nack, "R10 tx_err reflects card signal", cap_err, nack);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit badpar);
        logic [9:0] bits;
        bits[0] = 1'b0;
        for (int j = 0; j < 8; j++) bits[j+1] = msb_first ? d[7-j] : d[j];
        bits[9] = (^d) ^ badpar;
        got_rx = 0;
        t = 0;
        card_low = 1'b1;
        for (int k = 1; k < 10; k++) begin
            adv_to(k * ETU);
            card_low = !bits[k];
        end
        adv_to(10 * ETU);
        card_low = 1'b0;
        adv_to(10 * ETU + HALF);
        chk(io_drive_low == 1'b0, "R9 no drive before error window", io_drive_low, 0);
        adv_to(10 * ETU + HALF + 1);
        chk(io_drive_low == badpar, "R9 error window opens", io_drive_low, badpar);
        adv_to(11 * ETU + HALF);
        chk(io_drive_low == badpar, "R9 error window holds one ETU", io_drive_low, badpar);
        adv_to(11 * ETU + HALF + 1);
        chk(io_drive_low == 1'b0, "R9 error window closes", io_drive_low, 0);
        adv_to(12 * ETU + 1);
        chk(got_rx == 1'b1, "R8 rx_valid at guard end", got_rx, 1);
        chk(cap_rxd == d, msb_first ? "R3 msb-first receive" : "R8 received byte", cap_rxd, d);
        chk(cap_rxp == badpar, "R8 parity flag", cap_rxp, badpar);
        adv(2);
    endtask

    initial begin
        int n;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(io_drive_low == 1'b0, "R11 line released in reset", io_drive_low, 0);
        chk(card_clk == 1'b0, "R11 card clock low in reset", card_clk, 0);
        chk(!tx_done && !rx_valid, "R11 strobes low in reset", {tx_done, rx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        last_ck = card_clk;
        chk(io_drive_low == 1'b0 && !rx_valid, "R11 idle after reset", io_drive_low, 0);
        adv(3);

        // transmit, LSB first and MSB first with back-to-back chaining
        tx_frame(8'hA5, 0, 1'b0, 1'b0, 8'h00);
        adv(2);
        msb_first = 1'b1;
        tx_frame(8'h3C, 0, 1'b0, 1'b1, 8'h81);
        tx_frame(8'h81, 2, 1'b0, 1'b0, 8'h00);
        msb_first = 1'b0;
        adv(2);

        // card signals an error: byte held, new data refused, then resend
        tx_frame(8'h5E, 0, 1'b1, 1'b0, 8'h00);
        saw_drive = 0; saw_ready = 0;
        tx_data = 8'h00; tx_valid = 1'b1;
        adv(3 * ETU);
        tx_valid = 1'b0;
        chk(!saw_drive && !saw_ready, "R10 held byte blocks new data", {saw_drive, saw_ready}, 0);
        tx_frame(8'h5E, 1, 1'b0, 1'b0, 8'h00);
        adv(2);

        // receive mode: no transmit possible
        mode_rx = 1'b1;
        saw_drive = 0; saw_ready = 0;
        tx_data = 8'h11; tx_valid = 1'b1;
        adv(3 * ETU);
        tx_valid = 1'b0;
        chk(!saw_drive && !saw_ready, "R6 no transmit in receive mode", {saw_drive, saw_ready}, 0);

        rx_frame(8'hC3, 1'b0);
        rx_frame(8'h07, 1'b1);

        // false start (R7)
        got_rx = 0; saw_drive = 0; t = 0;
        card_low = 1'b1;
        adv(2);
        card_low = 1'b0;
        adv(13 * ETU);
        chk(!got_rx && !saw_drive, "R7 glitch shorter than half ETU dropped", {got_rx, saw_drive}, 0);
        rx_frame(8'h96, 1'b0);
        msb_first = 1'b1;
        rx_frame(8'hF0, 1'b0);
        msb_first = 1'b0;

        // back to transmit
        mode_rx = 1'b0;
        adv(3);
        tx_frame(8'hFF, 0, 1'b0, 1'b0, 8'h00);

        // divider change (R1)
        clk_div = 8'd3;
        adv(3);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (card_clk && !last_ck) begin last_ck = card_clk; break; end
            last_ck = card_clk;
        end
        chk(n == 6, "R1 card clock period 2*div", n, 6);
        clk_div = 8'd0;
        adv(3);
        chk(clk_bad == 0, "R1 card clock matches model every cycle", clk_bad, 0);
        summary();
    end
endmodule